// File: doc/BRIEF.md
# Dense Keyed Reduction Accumulator

The block keeps one accumulator for every key of a small key space that is fixed at build time. Each input item carries a key and a value. The block folds each value into the accumulator of its key as the item arrives, using a combine operation chosen from an addition, an unsigned minimum, an unsigned maximum and a bitwise OR. The accumulators sit in a synchronous-read array. Every accepted item is a read-modify-write. An update that lands on a key still in flight takes its old value from the pipeline rather than from the array, so no update is lost when items repeat a key.

A clear request loads every accumulator with the identity of the selected operation, one entry per cycle. The block also clears itself on its own after reset. A readout request streams every key with its final value over a valid/ready output. Keys come out in ascending order, and the last beat is flagged. While a clear or a readout is pending or running, the input is stalled. A pending request waits until the update pipeline is empty. Items whose key lies outside the key space are consumed and dropped, and a saturating counter records them.

A typical use is a histogram. The bin number is the key, every value is 1 and the operation is addition. The finished counts are then read out with one readout request.

Top module: `keyed_reduce_acc`

## Requirements
- R1: The accumulators start from the identity of the selected operation. After reset in_ready stays low for exactly NUM_KEYS cycles. After a clear request issued while the block is idle it stays low for NUM_KEYS+1 cycles.
- R2: op_sel codes and their identities are: 0 = addition modulo 2^VAL_W (identity 0), 1 = unsigned minimum (identity all ones), 2 = unsigned maximum (identity 0), 3 = bitwise OR (identity 0).
- R3: Every item accepted with in_key < NUM_KEYS replaces the accumulator of that key with the combine of its old value and in_val.
- R4: No update is lost when the same key is accepted in consecutive cycles or two cycles apart.
- R5: With value 1 and addition, each accumulator ends at the number of items that carried its key, so the block works as a histogram.
- R6: An item with in_key >= NUM_KEYS is accepted, changes no accumulator, and raises err_count by one. err_count saturates at 2^ERR_W-1 and only moves on such an item.
- R7: A readout emits exactly NUM_KEYS beats, keys 0 to NUM_KEYS-1 in ascending order, each beat carrying the final value of its key. out_last is high only on the beat for key NUM_KEYS-1.
- R8: While out_valid is high and out_ready is low, out_key and out_val hold their values.
- R9: in_ready is low from the cycle after a clear or readout request until that operation has finished. It is never high while out_valid is high. A request takes effect only once the update pipeline is empty.
- R10: When a clear and a readout are requested in the same cycle, the clear runs first, so the readout returns identity values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Combine operation select, held stable during a run |
| clear_req | input | 1 | One-cycle pulse requesting a clear of all accumulators |
| dump_req | input | 1 | One-cycle pulse requesting a readout of all accumulators |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can take an input item |
| in_key | input | KEY_W | Key of the input item |
| in_val | input | VAL_W | Value of the input item |
| out_valid | output | 1 | Readout beat valid |
| out_ready | input | 1 | Sink can take the readout beat |
| out_key | output | KEY_W | Key of the readout beat |
| out_val | output | VAL_W | Accumulated value of that key |
| out_last | output | 1 | Beat is the final key of the readout |
| err_count | output | ERR_W | Saturating count of out-of-range keys |

## Verification
The assertions check five properties on every cycle. Output beats hold under backpressure. Readout and input acceptance never overlap. The clear path and the update path never write the array in the same cycle. A mode change happens only with the update pipeline empty, and a clear walk covers the whole key range. The error counter moves by one and only after a dropped key. Whether the forwarding actually yields correct sums, minima and maxima can only be seen from the bench's scenarios. So can ascending readout order, the stall lengths after reset and clear, saturation of the error counter, and the ordering of a clear and a readout requested together. For these the bench streams repeated-key and mixed-key items under each operation and compares every readout beat with a behavioural model.

// File: rtl/kra_pkg.sv
package kra_pkg;

  // Combine operations; the encoding is visible on op_sel.
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_MIN = 2'd1,
    OP_MAX = 2'd2,
    OP_OR  = 2'd3
  } kra_op_e;

  // Block modes.
  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_DUMP  = 2'd2
  } kra_mode_e;

endpackage

// File: rtl/kra_mem.sv
module kra_mem #(
  parameter int DEPTH = 12,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [DEPTH];

  // Read-before-write: a read and a write to one address in the same
  // cycle return the old contents.
  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/kra_update.sv
module kra_update
  import kra_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kra_op_e       op,
  input  logic          take,
  input  logic [AW-1:0] take_key,
  input  logic [DW-1:0] take_val,
  input  logic [DW-1:0] rd_data,
  output logic          upd_we,
  output logic [AW-1:0] upd_addr,
  output logic [DW-1:0] upd_data,
  output logic          upd_busy
);

  function automatic logic [DW-1:0] fold(input kra_op_e o,
                                         input logic [DW-1:0] acc,
                                         input logic [DW-1:0] v);
    case (o)
      OP_ADD:  fold = acc + v;
      OP_MIN:  fold = (v < acc) ? v : acc;
      OP_MAX:  fold = (v > acc) ? v : acc;
      default: fold = acc | v;
    endcase
  endfunction

  // Stage 1: the array read issued on acceptance returns here.
  logic          s1_valid;
  logic [AW-1:0] s1_key;
  logic [DW-1:0] s1_val;
  // Stage 2: copy of the value written last cycle, used for forwarding.
  logic          s2_valid;
  logic [AW-1:0] s2_key;
  logic [DW-1:0] s2_data;

  logic          fwd_hit;
  logic [DW-1:0] old_val;
  logic [DW-1:0] new_val;

  assign fwd_hit = s2_valid && (s2_key == s1_key);
  assign old_val = fwd_hit ? s2_data : rd_data;
  assign new_val = fold(op, old_val, s1_val);

  assign upd_we   = s1_valid;
  assign upd_addr = s1_key;
  assign upd_data = new_val;
  assign upd_busy = s1_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_key   <= '0;
      s1_val   <= '0;
      s2_valid <= 1'b0;
      s2_key   <= '0;
      s2_data  <= '0;
    end else begin
      s1_valid <= take;
      if (take) begin
        s1_key <= take_key;
        s1_val <= take_val;
      end
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_key  <= s1_key;
        s2_data <= new_val;
      end
    end
  end

endmodule

// File: rtl/kra_ctrl.sv
module kra_ctrl
  import kra_pkg::*;
#(
  parameter int NUM_KEYS = 12,
  parameter int AW       = 4,
  parameter int DW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  kra_op_e       op,
  input  logic          clear_req,
  input  logic          dump_req,
  input  logic          upd_busy,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          clr_we,
  output logic [AW-1:0] clr_addr,
  output logic [DW-1:0] clr_data,
  output logic          dump_re,
  output logic [AW-1:0] dump_addr,
  output logic          out_valid,
  output logic [AW-1:0] out_key,
  output logic          out_last
);

  localparam logic [AW-1:0] LAST = AW'(NUM_KEYS - 1);

  function automatic logic [DW-1:0] neutral(input kra_op_e o);
    neutral = (o == OP_MIN) ? {DW{1'b1}} : '0;
  endfunction

  kra_mode_e     mode;
  logic [AW-1:0] ptr;
  logic          pend_clr;
  logic          pend_dump;
  logic          all_issued;
  logic          sink_free;

  assign sink_free = !out_valid || out_ready;
  assign in_ready  = (mode == MODE_RUN) && !pend_clr && !pend_dump;
  assign clr_we    = (mode == MODE_CLEAR);
  assign clr_addr  = ptr;
  assign clr_data  = neutral(op);
  assign dump_re   = (mode == MODE_DUMP) && !all_issued && sink_free;
  assign dump_addr = ptr;
  assign out_last  = out_valid && (out_key == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_CLEAR;
      ptr        <= '0;
      pend_clr   <= 1'b0;
      pend_dump  <= 1'b0;
      all_issued <= 1'b0;
      out_valid  <= 1'b0;
      out_key    <= '0;
    end else begin
      if (clear_req) pend_clr  <= 1'b1;
      if (dump_req)  pend_dump <= 1'b1;
      case (mode)
        MODE_CLEAR: begin
          if (ptr == LAST) begin
            ptr  <= '0;
            mode <= MODE_RUN;
          end else begin
            ptr <= ptr + 1'b1;
          end
        end
        MODE_RUN: begin
          if (!upd_busy) begin
            if (pend_clr) begin
              mode     <= MODE_CLEAR;
              ptr      <= '0;
              pend_clr <= clear_req;
            end else if (pend_dump) begin
              mode       <= MODE_DUMP;
              ptr        <= '0;
              all_issued <= 1'b0;
              pend_dump  <= dump_req;
            end
          end
        end
        MODE_DUMP: begin
          if (dump_re) begin
            out_valid <= 1'b1;
            out_key   <= ptr;
            if (ptr == LAST) all_issued <= 1'b1;
            else             ptr        <= ptr + 1'b1;
          end else if (out_ready) begin
            out_valid <= 1'b0;
          end
          if (all_issued && sink_free) begin
            mode      <= MODE_RUN;
            out_valid <= 1'b0;
            ptr       <= '0;
          end
        end
        default: mode <= MODE_RUN;
      endcase
    end
  end

  // R1: a clear walk ends only after the last key has been written.
  a_r1_clear_covers_all: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_CLEAR && mode == MODE_RUN) |-> ($past(ptr) == LAST));

  // R9: leaving the run mode needs an empty update pipeline.
  a_r9_drained_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == MODE_RUN && mode != MODE_RUN) |-> !$past(upd_busy));

  // R8: a stalled beat keeps its key.
  a_r8_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_key)));

endmodule

// File: rtl/keyed_reduce_acc.sv
module keyed_reduce_acc
  import kra_pkg::*;
#(
  parameter int KEY_W    = 4,
  parameter int NUM_KEYS = 12,
  parameter int VAL_W    = 16,
  parameter int ERR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op_sel,
  input  logic             clear_req,
  input  logic             dump_req,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [KEY_W-1:0] in_key,
  input  logic [VAL_W-1:0] in_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [KEY_W-1:0] out_key,
  output logic [VAL_W-1:0] out_val,
  output logic             out_last,
  output logic [ERR_W-1:0] err_count
);

  localparam logic [KEY_W:0] KEY_LIMIT = (KEY_W + 1)'(NUM_KEYS);

  kra_op_e op;
  assign op = kra_op_e'(op_sel);

  logic             in_fire;
  logic             key_ok;
  logic             upd_take;
  logic             key_drop;
  logic             clr_we;
  logic [KEY_W-1:0] clr_addr;
  logic [VAL_W-1:0] clr_data;
  logic             upd_we;
  logic [KEY_W-1:0] upd_addr;
  logic [VAL_W-1:0] upd_data;
  logic             upd_busy;
  logic             dump_re;
  logic [KEY_W-1:0] dump_addr;
  logic             mem_we;
  logic [KEY_W-1:0] mem_waddr;
  logic [VAL_W-1:0] mem_wdata;
  logic             mem_re;
  logic [KEY_W-1:0] mem_raddr;
  logic [VAL_W-1:0] mem_rdata;
  logic [ERR_W-1:0] err_q;

  assign in_fire  = in_valid && in_ready;
  assign key_ok   = {1'b0, in_key} < KEY_LIMIT;
  assign upd_take = in_fire && key_ok;
  assign key_drop = in_fire && !key_ok;

  assign mem_we    = clr_we || upd_we;
  assign mem_waddr = clr_we ? clr_addr : upd_addr;
  assign mem_wdata = clr_we ? clr_data : upd_data;
  assign mem_re    = upd_take || dump_re;
  assign mem_raddr = dump_re ? dump_addr : in_key;

  kra_ctrl #(.NUM_KEYS(NUM_KEYS), .AW(KEY_W), .DW(VAL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .op(op),
    .clear_req(clear_req), .dump_req(dump_req),
    .upd_busy(upd_busy), .out_ready(out_ready), .in_ready(in_ready),
    .clr_we(clr_we), .clr_addr(clr_addr), .clr_data(clr_data),
    .dump_re(dump_re), .dump_addr(dump_addr),
    .out_valid(out_valid), .out_key(out_key), .out_last(out_last)
  );

  kra_update #(.AW(KEY_W), .DW(VAL_W)) u_update (
    .clk(clk), .rst_n(rst_n), .op(op),
    .take(upd_take), .take_key(in_key), .take_val(in_val),
    .rd_data(mem_rdata),
    .upd_we(upd_we), .upd_addr(upd_addr), .upd_data(upd_data),
    .upd_busy(upd_busy)
  );

  kra_mem #(.DEPTH(NUM_KEYS), .AW(KEY_W), .DW(VAL_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_rdata)
  );

  assign out_val = mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         err_q <= '0;
    else if (key_drop && err_q != '1)   err_q <= err_q + 1'b1;
  end
  assign err_count = err_q;

  // R6: the counter only steps by one, right after a dropped key.
  a_r6_err_step: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count != $past(err_count)) |->
      ($past(key_drop) && err_count == $past(err_count) + 1'b1));

  // R9: readout and input acceptance never overlap.
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9: the clear walk and the update pipeline never write together.
  a_r9_no_write_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr_we && upd_we));

  // R8: a stalled beat keeps its value.
  a_r8_val_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_val));

endmodule

// File: tb/keyed_reduce_acc_bench.sv
`timescale 1ns/1ps
module keyed_reduce_acc_bench;

  localparam int KEY_W = 4;
  localparam int NK    = 12;
  localparam int VAL_W = 16;
  localparam int ERR_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       op_sel = 2'd0;
  logic             clear_req = 1'b0;
  logic             dump_req = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [KEY_W-1:0] in_key = '0;
  logic [VAL_W-1:0] in_val = '0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [KEY_W-1:0] out_key;
  logic [VAL_W-1:0] out_val;
  logic             out_last;
  logic [ERR_W-1:0] err_count;

  keyed_reduce_acc #(.KEY_W(KEY_W), .NUM_KEYS(NK), .VAL_W(VAL_W), .ERR_W(ERR_W))
  u_keyed_reduce_acc (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .clear_req(clear_req),
    .dump_req(dump_req), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_val(in_val), .out_valid(out_valid),
    .out_ready(out_ready), .out_key(out_key), .out_val(out_val),
    .out_last(out_last), .err_count(err_count)
  );

  always #2 clk = ~clk;  // 250 MHz

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int exp_err = 0;
  int exp_ptr = 0;
  int beats = 0;
  bit prev_stall = 0;
  logic [KEY_W-1:0] prev_key;
  logic [VAL_W-1:0] prev_val;
  logic [VAL_W-1:0] model [NK];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // Model of the combine rules (R2), written from the requirement.
  function automatic logic [VAL_W-1:0] apply_op(input int code,
      input logic [VAL_W-1:0] a, input logic [VAL_W-1:0] b);
    longint s;
    if (code == 0) begin s = longint'(a) + longint'(b); return s[VAL_W-1:0]; end
    if (code == 1) return (a <= b) ? a : b;
    if (code == 2) return (a >= b) ? a : b;
    return a | b;
  endfunction

  function automatic logic [VAL_W-1:0] start_value(input int code);
    return (code == 1) ? 16'hFFFF : 16'h0000;
  endfunction

  // Per-cycle reference model and comparison, sampled 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      check(err_count == ERR_W'(exp_err), "R6", "err_count", err_count, exp_err);
      if (out_valid && in_ready)
        check(1'b0, "R9", "in_ready while out_valid", 1, 0);
      if (prev_stall) begin
        check(out_valid && out_key == prev_key && out_val == prev_val,
              "R8", "stalled beat changed key", out_key, prev_key);
      end
      if (in_valid && in_ready) begin
        if (int'(in_key) < NK) model[in_key] = apply_op(int'(op_sel), model[in_key], in_val);
        else if (exp_err < (1 << ERR_W) - 1) exp_err++;
      end
      if (clear_req) foreach (model[i]) model[i] = start_value(int'(op_sel));
      if (dump_req) exp_ptr = 0;
      if (out_valid && out_ready) begin
        check(int'(out_key) == exp_ptr, "R7", "readout key order", out_key, exp_ptr);
        if (exp_ptr < NK)
          check(out_val == model[exp_ptr], "R3", "readout value", out_val, model[exp_ptr]);
        check(out_last == (exp_ptr == NK - 1), "R7", "out_last flag", out_last, exp_ptr == NK - 1);
        exp_ptr++;
        beats++;
      end
      prev_stall = out_valid && !out_ready;
      prev_key = out_key;
      prev_val = out_val;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic send(input logic [KEY_W-1:0] k, input logic [VAL_W-1:0] v);
    in_valid = 1'b1;
    in_key = k;
    in_val = v;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    while (!in_ready) @(negedge clk);
  endtask

  task automatic dump(input bit stall, input string req);
    @(negedge clk);
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    beats = 0;
    for (int k = 0; beats < NK && k < 2000; k++) begin
      out_ready = stall ? ((k % 3) != 0) : 1'b1;
      @(negedge clk);
    end
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(beats == NK, req, "readout beat count", beats, NK);
    check(!out_valid && in_ready, req, "back to accepting", in_ready, 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && err_count == 0, "R1", "reset state", in_ready, 0);
    rst_n = 1'b1;
    n = 0;
    while (!in_ready) begin @(negedge clk); n++; end
    check(n == NK, "R1", "stall cycles after reset", n, NK);
    foreach (model[i]) model[i] = 16'h0000;

    // Addition: initial zeros, repeated keys, wrap, drop, histogram.
    dump(1'b0, "R1");
    send(4'd3, 16'd5); send(4'd3, 16'd7); send(4'd3, 16'd1);      // R4 consecutive
    send(4'd5, 16'd10); send(4'd6, 16'd1); send(4'd5, 16'd2);     // R4 two apart
    send(4'd0, 16'hFFFF); send(4'd0, 16'd3);                      // R2 wrap
    send(4'd14, 16'd9);                                           // R6 dropped
    for (int i = 0; i < 20; i++) send(4'(8 + (i % 4)), 16'd1);    // R5 histogram
    dump(1'b1, "R5");
    check(err_count == 1, "R6", "one dropped key", err_count, 1);

    // Minimum.
    op_sel = 2'd1;
    pulse_clear();
    dump(1'b0, "R2");
    send(4'd2, 16'd900); send(4'd2, 16'd40); send(4'd2, 16'd700);
    send(4'd11, 16'd5); send(4'd1, 16'd3); send(4'd11, 16'd1);
    dump(1'b1, "R3");

    // Maximum, with clear and readout requested together.
    op_sel = 2'd2;
    @(negedge clk);
    clear_req = 1'b1; dump_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0; dump_req = 1'b0;
    beats = 0;
    for (int k = 0; beats < NK && k < 200; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(beats == NK, "R10", "readout after joint request", beats, NK);
    send(4'd7, 16'd3); send(4'd7, 16'd300); send(4'd7, 16'd30);
    send(4'd4, 16'd8); send(4'd9, 16'd2); send(4'd4, 16'd6);
    dump(1'b0, "R3");

    // Bitwise OR, plus stall length of a clear from idle.
    op_sel = 2'd3;
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    check(!in_ready, "R9", "in_ready after clear request", in_ready, 0);
    n = 1;
    while (!in_ready) begin @(negedge clk); n++; end
    check(n - 1 == NK + 1, "R1", "stall cycles after clear", n - 1, NK + 1);
    send(4'd10, 16'h0101); send(4'd10, 16'h1010); send(4'd0, 16'h8000);
    send(4'd10, 16'h0001);
    dump(1'b1, "R3");

    // Error counter saturation.
    for (int i = 0; i < 300; i++) send(4'(12 + (i % 4)), 16'd1);
    repeat (2) @(negedge clk);
    check(err_count == 8'hFF, "R6", "err_count saturates", err_count, 255);
    dump(1'b0, "R6");

    finish_run();
  end

endmodule